// File: doc/BRIEF.md
# Left-to-right modular exponentiation engine

This block raises a message value to a power modulo a given modulus, C = M^e mod n, for operands of configurable width. A start strobe captures M, e and n. The engine then walks the exponent from its leading one bit down to bit 0. For each bit it first squares the running value and then, only if the bit is 1, multiplies it by M.

All squarings and multiplications run in turn on one internal bit-serial modular multiplier. That multiplier consumes one bit of its second operand per clock. Each step doubles the partial result, may add the first operand, and then removes n at most twice, so every partial value stays below n.

A busy flag covers the whole run. A one-cycle done pulse marks the end. The result stays on the output until the next accepted start. Callers must present 0 <= M < n with n >= 1.

Top module: `modexp_lr`

## Requirements
- R1: For 0 <= M < n and n >= 1, the value on `c` during the done pulse equals M^e mod n, and it is below n.
- R2: With e = 0 the result is 1 mod n: 1 when n > 1, and 0 when n = 1. With e nonzero, the running value is seeded with M at the exponent's highest set bit, and the loop covers only the bits below it.
- R3: With e = 1 the result is M and no loop step runs. `done` is high in the second cycle after the clock edge that accepts `start`.
- R4: Bits are consumed from most to least significant. Each bit costs one squaring, followed by a multiply by M only when that bit is 1. A multiply is never issued unless a squaring was issued before it in the same bit. Exponents with only the top bit set and with all bits set give correct results.
- R5: A single multiplier serves every operation, with at most one operation in flight. A run issues at most 2*EW operations, so an all-ones exponent finishes within 4 + (EW-1)*(2*(W+4)+1) cycles of the accepting edge.
- R6: `busy` rises at the edge that accepts `start` and stays high through the done cycle. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R7: A `start` seen while `busy` is high is ignored: the run in progress completes with its original operands.
- R8: After done, `c` keeps the result unchanged until the next accepted `start`.
- R9: After reset, `busy` = 0, `done` = 0 and `c` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| m | input | W | Base (message), below n |
| e | input | EW | Exponent |
| n | input | W | Modulus, at least 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| c | output | W | Result, held until the next start |

## Verification
The bench goes after the exponent edges: zero, one, only the top bit set, and all ones. A wrong seed shows up as an e = 0 result of 1 even when n = 1, or as an e = 1 run that is off by a squaring or takes extra cycles. A scan in the wrong direction or a skipped squaring corrupts the top-bit-only and all-ones results. It also drives M = 0, M = n-1 and n = 1, where a multiplier that reduces only once escapes the range below n. A second start during a run would, if honoured, replace the operands and give the wrong answer for the first request. A result register that moves while idle breaks the hold check.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SQUARE,
    ST_MULTIPLY,
    ST_NEXT_BIT,
    ST_DONE
  } state_t;
endpackage

// File: rtl/modexp_msb_find.sv
module modexp_msb_find #(
  parameter int EW = 16,
  localparam int IW = $clog2(EW)
) (
  input  logic [EW-1:0] vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < EW; i++) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/modexp_modmul.sv
module modexp_modmul #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kick,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] p
);
  logic [W-1:0]  a_q, b_sh, n_q, r;
  logic [CW-1:0] cnt;

  // one bit-serial step: 2r (+a), then at most two subtractions of the modulus
  function automatic logic [W-1:0] mm_step(input logic [W-1:0] acc,
                                           input logic [W-1:0] addend,
                                           input logic         bit_i,
                                           input logic [W-1:0] md);
    logic [W+1:0] t;
    t = {1'b0, acc, 1'b0} + (bit_i ? {2'b00, addend} : '0);
    if (t >= {2'b00, md}) t = t - {2'b00, md};
    if (t >= {2'b00, md}) t = t - {2'b00, md};
    return t[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_sh <= '0;
      n_q  <= '0;
      r    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (kick) begin
        a_q  <= a;
        b_sh <= b;
        n_q  <= n;
        r    <= '0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        r    <= mm_step(r, a_q, b_sh[W-1], n_q);
        b_sh <= b_sh << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign p = r;
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 16,
  localparam int IW = $clog2(EW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  m,
  input  logic [EW-1:0] e,
  input  logic [W-1:0]  n,
  input  logic          mm_done,
  input  logic [W-1:0]  mm_p,
  output state_t        st,
  output logic [W-1:0]  acc,
  output logic [W-1:0]  m_q,
  output logic [EW-1:0] e_q,
  output logic [W-1:0]  n_q,
  output logic          sq_kick,
  output logic          mu_kick,
  output logic [W-1:0]  mm_b
);
  logic [IW-1:0] lead_idx;
  logic          lead_any;
  logic [IW-1:0] idx;

  modexp_msb_find #(.EW(EW)) u_msb (
    .vec (e_q),
    .idx (lead_idx),
    .any (lead_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      acc     <= '0;
      m_q     <= '0;
      e_q     <= '0;
      n_q     <= '0;
      idx     <= '0;
      sq_kick <= 1'b0;
      mu_kick <= 1'b0;
    end else begin
      sq_kick <= 1'b0;
      mu_kick <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          m_q <= m;
          e_q <= e;
          n_q <= n;
          st  <= ST_INIT;
        end
        ST_INIT: begin
          if (!lead_any) begin
            acc <= (n_q == W'(1)) ? '0 : W'(1);
            st  <= ST_DONE;
          end else begin
            acc <= m_q;
            if (lead_idx == '0) begin
              st <= ST_DONE;
            end else begin
              idx     <= lead_idx - 1'b1;
              st      <= ST_SQUARE;
              sq_kick <= 1'b1;
            end
          end
        end
        ST_SQUARE: if (mm_done) begin
          acc <= mm_p;
          if (e_q[idx]) begin
            st      <= ST_MULTIPLY;
            mu_kick <= 1'b1;
          end else begin
            st <= ST_NEXT_BIT;
          end
        end
        ST_MULTIPLY: if (mm_done) begin
          acc <= mm_p;
          st  <= ST_NEXT_BIT;
        end
        ST_NEXT_BIT: begin
          if (idx == '0) begin
            st <= ST_DONE;
          end else begin
            idx     <= idx - 1'b1;
            st      <= ST_SQUARE;
            sq_kick <= 1'b1;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mm_b = (st == ST_MULTIPLY) ? m_q : acc;
endmodule

// File: rtl/modexp_lr.sv
module modexp_lr
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  m,
  input  logic [EW-1:0] e,
  input  logic [W-1:0]  n,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  c
);
  state_t        st;
  logic [W-1:0]  acc, m_q, n_q, mm_b, mm_p;
  logic [EW-1:0] e_q;
  logic          sq_kick, mu_kick, mm_kick, mm_busy, mm_done;

  modexp_ctrl #(.W(W), .EW(EW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .m       (m),
    .e       (e),
    .n       (n),
    .mm_done (mm_done),
    .mm_p    (mm_p),
    .st      (st),
    .acc     (acc),
    .m_q     (m_q),
    .e_q     (e_q),
    .n_q     (n_q),
    .sq_kick (sq_kick),
    .mu_kick (mu_kick),
    .mm_b    (mm_b)
  );

  assign mm_kick = sq_kick | mu_kick;

  modexp_modmul #(.W(W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (mm_kick),
    .a     (acc),
    .b     (mm_b),
    .n     (n_q),
    .busy  (mm_busy),
    .done  (mm_done),
    .p     (mm_p)
  );

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);
  assign c    = acc;
endmodule

// File: rtl/modexp_lr_chk.sv
module modexp_lr_chk #(
  parameter int W  = 16,
  parameter int EW = 16,
  localparam int OW = $clog2(2 * EW + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  c,
  input logic [W-1:0]  m_q,
  input logic [EW-1:0] e_q,
  input logic [W-1:0]  n_q,
  input logic          sq_kick,
  input logic          mu_kick,
  input logic          mm_busy
);
  logic          last_sq;
  logic [OW-1:0] ops;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sq <= 1'b0;
      ops     <= '0;
    end else begin
      if (sq_kick) last_sq <= 1'b1;
      else if (mu_kick) last_sq <= 1'b0;
      if (!busy) ops <= '0;
      else if (sq_kick || mu_kick) ops <= ops + 1'b1;
    end
  end

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (c < n_q)); // R1
  AST_SQ_BEFORE_MUL: assert property (@(posedge clk) disable iff (!rst_n) mu_kick |-> last_sq); // R4
  AST_SINGLE_MUL: assert property (@(posedge clk) disable iff (!rst_n) (sq_kick || mu_kick) |-> (!mm_busy && $onehot0({sq_kick, mu_kick}))); // R5
  AST_OP_BUDGET: assert property (@(posedge clk) disable iff (!rst_n) (sq_kick || mu_kick) |-> (ops < OW'(2 * EW))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R6
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> ($stable(m_q) && $stable(e_q) && $stable(n_q))); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(c)); // R8
endmodule

bind modexp_lr modexp_lr_chk #(.W(W), .EW(EW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .c       (c),
  .m_q     (m_q),
  .e_q     (e_q),
  .n_q     (n_q),
  .sq_kick (sq_kick),
  .mu_kick (mu_kick),
  .mm_busy (mm_busy)
);

// File: tb/modexp_lr_tb_top.sv
`timescale 1ns/1ps
module modexp_lr_tb_top;
  localparam int W  = 16;
  localparam int EW = 16;
  localparam int LAT_MAX = 4 + (EW - 1) * (2 * (W + 4) + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  m = '0, n = '0;
  logic [EW-1:0] e = '0;
  logic          busy, done;
  logic [W-1:0]  c;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  modexp_lr #(.W(W), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .m(m), .e(e), .n(n),
    .busy(busy), .done(done), .c(c)
  );

  // right-to-left reference, computed independently of the design
  function automatic longint unsigned ref_pow(longint unsigned bm, longint unsigned ex,
                                              longint unsigned md);
    longint unsigned r = 1 % md;
    longint unsigned b = bm % md;
    for (int i = 0; i < EW; i++) begin
      if (ex[i]) r = (r * b) % md;
      b = (b * b) % md;
    end
    return r;
  endfunction

  task automatic check(string req, longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // launch, wait for done; returns the result and the cycle count to done
  task automatic run(input logic [W-1:0] mi, input logic [EW-1:0] ei, input logic [W-1:0] ni,
                     output logic [W-1:0] res, output int lat);
    @(negedge clk);
    m = mi; e = ei; n = ni; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100000) begin
      @(negedge clk);
      lat++;
    end
    res = c;
  endtask

  task automatic op(string req, logic [W-1:0] mi, logic [EW-1:0] ei, logic [W-1:0] ni);
    logic [W-1:0] res;
    int lat;
    run(mi, ei, ni, res, lat);
    check(req, res, ref_pow(mi, ei, ni));
  endtask

  initial begin
    logic [W-1:0] res, res2;
    int lat;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 c", c, 0);
    rst_n = 1'b1;

    // R2 zero exponent
    op("R2 e=0", 16'h1234, 16'h0000, 16'hF00D);
    check("R2 e=0 is 1", c, 1);
    op("R2 e=0 n=1", 16'h0000, 16'h0000, 16'h0001);
    check("R2 e=0 n=1 is 0", c, 0);

    // R3 e=1
    run(16'h4321, 16'h0001, 16'hFFF1, res, lat);
    check("R3 e=1 value", res, 16'h4321);
    check("R3 e=1 latency", lat, 2);

    // R4 top-bit only and all ones
    op("R4 top bit only", 16'h0003, 16'h8000, 16'hFFF1);
    run(16'hBEEF, 16'hFFFF, 16'hFFFB, res, lat);
    check("R4 all ones", res, ref_pow(16'hBEEF, 16'hFFFF, 16'hFFFB));
    check("R5 latency bound", (lat <= LAT_MAX) ? 1 : 0, 1);

    // R1 boundary operands
    op("R1 M=0", 16'h0000, 16'h0013, 16'h00FF);
    op("R1 M=n-1", 16'hFFFE, 16'h0A5B, 16'hFFFF);
    op("R1 n=1", 16'h0000, 16'h7777, 16'h0001);
    op("R1 n=2", 16'h0001, 16'h0006, 16'h0002);

    // R6 busy and done timing
    @(negedge clk);
    m = 16'h0077; e = 16'h0005; n = 16'h0101; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 busy after accept", busy, 1);
    lat = 0;
    while (!done && lat < 100000) begin @(negedge clk); lat++; end
    check("R6 busy during done", busy, 1);
    @(negedge clk);
    check("R6 done one cycle", done, 0);
    check("R6 busy low after done", busy, 0);

    // R8 hold
    res = c;
    repeat (20) @(negedge clk);
    check("R8 result held", c, res);
    check("R8 result value", res, ref_pow(16'h0077, 16'h0005, 16'h0101));

    // R7 start while busy ignored
    @(negedge clk);
    m = 16'h0123; e = 16'h00F3; n = 16'h7FED; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    m = 16'h0002; e = 16'h0003; n = 16'h0005; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100000) begin @(negedge clk); lat++; end
    res2 = c;
    check("R7 second start ignored", res2, ref_pow(16'h0123, 16'h00F3, 16'h7FED));

    // R1 random operands
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] rn, rm;
      logic [EW-1:0] re;
      rn = W'($urandom);
      if (rn < 2) rn = 16'd3;
      rm = W'($urandom % rn);
      re = (k % 2 == 0) ? EW'($urandom & 32'hFF) : EW'($urandom);
      op("R1 random", rm, re, rn);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule